// File: doc/BRIEF.md
# Multichannel Digital Silence Detector

This block watches six parallel audio sample channels and reports, on an active-low flag, when the program material has gone digitally silent. One sample-valid strobe carries one sample period for all channels. A counter tracks how many consecutive sample periods every participating channel has held an all-zero word. When that run reaches a threshold (9600 sample periods by default, about 200 ms at 48 kHz), the flag goes low. External logic can use it to mute an output or pause a recorder.

Two control sources decide which channels take part. In control-port mode, a per-channel enable mask picks the channels that are watched. In static mode, all six channels are watched whatever the mask holds. A mute request forces the flag low at any time, whatever the samples hold.

The flag is registered. Every decision takes effect on the clock edge that samples the inputs causing it. A synchronous reset restarts the silence run.

Top module: `silence_watch`

## Requirements
- R1: The block takes six channels, each `SAMPLE_W` bits wide (default 24). Channel i sits at bits [i*SAMPLE_W +: SAMPLE_W] of `sampleBus`. A sample counts as zero only when every bit is zero, so a word with only the sign bit set (0x800000) is non-zero.
- R2: `silenceN` is active low: 0 means silent or muted, 1 means program material is present.
- R3: The silence run changes only on clock edges where `sampleValid` is 1. With `sampleValid` at 0, non-zero samples have no effect on the run or the flag.
- R4: `silenceN` goes to 0 on the edge that samples the `QUIET_RUN`-th consecutive strobe with all participating channels zero, and not one strobe earlier. The count saturates, so the flag stays 0 for any number of further quiet strobes.
- R5: A strobe with a non-zero sample on a participating channel restarts the run from zero and drives `silenceN` to 1 on that edge, unless mute is requested.
- R6: With `staticMode` = 0, bit i of `chanEnable` set to 1 makes channel i participate. A channel whose bit is 0 is ignored, even when it carries non-zero samples.
- R7: With `staticMode` = 1, all six channels participate, whatever `chanEnable` holds.
- R8: While `muteReq` is 1, `silenceN` is 0 from the next clock edge onward, whatever the samples and the strobe hold.
- R9: With `staticMode` = 0 and `chanEnable` all zero, no channel can break the run, so `silenceN` goes to 0 after `QUIET_RUN` strobes.
- R10: A synchronous `rst` clears the run and drives `silenceN` to 1. After reset, a fresh run of `QUIET_RUN` strobes is needed before the flag goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | One sample period for all channels is present |
| sampleBus | input | NUM_CH*SAMPLE_W | Six signed samples, channel i at bits [i*SAMPLE_W +: SAMPLE_W] |
| chanEnable | input | NUM_CH | Participation mask, used in control-port mode |
| staticMode | input | 1 | 1 makes all channels participate |
| muteReq | input | 1 | Forces the silence flag low |
| silenceN | output | 1 | Active-low silence flag |

## Verification
The bench looks for the flag one strobe early and one strobe late at the threshold. A design that is off by one in either direction fails there. It checks that the flag holds through long silence, which catches a counter that wraps and releases the flag. It drives a sign-bit-only word to expose a zero test that looks at the magnitude only. It drives a loud sample on a masked channel, both in control-port mode and in static mode, to catch inverted or ignored participation logic. It tests an empty mask, mute without a strobe, loud samples with the strobe low, and a reset in the middle of a silence. Each of these catches a design that ignores a control or reacts without a strobe.

// File: rtl/silence_pkg.sv
package silence_pkg;

  // Strobes from control to the run counter in the datapath
  typedef struct packed {
    logic clearCnt;
    logic advanceCnt;
  } ctlStrobes_t;

endpackage

// File: rtl/silence_datapath.sv
module silence_datapath
  import silence_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int SAMPLE_W  = 24,
  parameter int QUIET_RUN = 9600
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sampleValid,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleBus,
  input  logic [NUM_CH-1:0]          chanEnable,
  input  logic                       staticMode,
  input  ctlStrobes_t                strobes,
  output logic                       anyLoud,
  output logic                       cntAtLast,
  output logic                       cntFull
);

  localparam int CNT_W = $clog2(QUIET_RUN + 1);
  localparam logic [CNT_W-1:0] FULL_VAL = CNT_W'(QUIET_RUN);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(QUIET_RUN - 1);

  logic [NUM_CH-1:0] chQuiet;
  logic [NUM_CH-1:0] participate;
  logic [CNT_W-1:0]  runCount;

  // One zero test per channel
  for (genvar g = 0; g < NUM_CH; g++) begin : g_zero
    assign chQuiet[g] = (sampleBus[g*SAMPLE_W +: SAMPLE_W] == '0);
  end

  assign participate = staticMode ? {NUM_CH{1'b1}} : chanEnable;
  assign anyLoud     = |(participate & ~chQuiet);

  always_ff @(posedge clk) begin
    if (rst)                     runCount <= '0;
    else if (strobes.clearCnt)   runCount <= '0;
    else if (strobes.advanceCnt) runCount <= runCount + 1'b1;
  end

  assign cntFull   = (runCount == FULL_VAL);
  assign cntAtLast = (runCount == LAST_VAL);

  // R4: the run never passes the threshold
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    runCount <= FULL_VAL);

  // R5: a loud participating strobe restarts the run
  a_r5_loud_clears: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && anyLoud) |=> (runCount == '0));

  // R3: without a strobe the run holds
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> $stable(runCount));

endmodule

// File: rtl/silence_control.sv
module silence_control
  import silence_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sampleValid,
  input  logic        muteReq,
  input  logic        anyLoud,
  input  logic        cntAtLast,
  input  logic        cntFull,
  output ctlStrobes_t strobes,
  output logic        silenceN
);

  logic nextFull;

  always_comb begin
    strobes.clearCnt   = sampleValid & anyLoud;
    strobes.advanceCnt = sampleValid & ~anyLoud & ~cntFull;
    if (cntFull) nextFull = ~strobes.clearCnt;
    else         nextFull = strobes.advanceCnt & cntAtLast;
  end

  always_ff @(posedge clk) begin
    if (rst) silenceN <= 1'b1;
    else     silenceN <= ~(muteReq | nextFull);
  end

  // R8: mute forces the flag low on the next edge
  a_r8_mute_forces: assert property (@(posedge clk) disable iff (rst)
    muteReq |=> !silenceN);

  // R5: a loud strobe without mute releases the flag
  a_r5_loud_releases: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && anyLoud && !muteReq) |=> silenceN);

  // R3: with no strobe and no mute, the flag does not fall
  a_r3_no_fall_idle: assert property (@(posedge clk) disable iff (rst)
    (!sampleValid && !muteReq && silenceN) |=> silenceN);

endmodule

// File: rtl/silence_watch.sv
module silence_watch
  import silence_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int SAMPLE_W  = 24,
  parameter int QUIET_RUN = 9600
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sampleValid,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleBus,
  input  logic [NUM_CH-1:0]          chanEnable,
  input  logic                       staticMode,
  input  logic                       muteReq,
  output logic                       silenceN
);

  ctlStrobes_t strobes;
  logic anyLoud;
  logic cntAtLast;
  logic cntFull;

  silence_datapath #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .QUIET_RUN(QUIET_RUN)
  ) u_datapath (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleBus(sampleBus),
    .chanEnable(chanEnable), .staticMode(staticMode), .strobes(strobes),
    .anyLoud(anyLoud), .cntAtLast(cntAtLast), .cntFull(cntFull)
  );

  silence_control u_control (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .muteReq(muteReq),
    .anyLoud(anyLoud), .cntAtLast(cntAtLast), .cntFull(cntFull),
    .strobes(strobes), .silenceN(silenceN)
  );

endmodule

// File: tb/silence_watch_bench.sv
module silence_watch_bench;

  localparam int NCH = 6;
  localparam int SW  = 24;
  localparam int QR  = 9600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleValid = 1'b0;
  logic [NCH*SW-1:0] sampleBus = '0;
  logic [NCH-1:0] chanEnable = '0;
  logic staticMode = 1'b0;
  logic muteReq = 1'b0;
  logic silenceN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  silence_watch u_silence_watch (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleBus(sampleBus),
    .chanEnable(chanEnable), .staticMode(staticMode), .muteReq(muteReq),
    .silenceN(silenceN)
  );

  typedef struct packed {
    logic        stat;
    logic [5:0]  mask;
    logic        mute;
    logic [2:0]  loudCh;   // 7 = all channels zero
    logic [23:0] loudVal;
    logic [15:0] nStrobe;
    logic        expN;
    logic [7:0]  req;
  } step_t;

  localparam step_t STEPS [9] = '{
    '{1'b0, 6'h3F, 1'b0, 3'd7, 24'h0,      16'd9599, 1'b1, 8'd4},  // R4 one short
    '{1'b0, 6'h3F, 1'b0, 3'd7, 24'h0,      16'd1,    1'b0, 8'd4},  // R4 exact
    '{1'b0, 6'h3F, 1'b0, 3'd7, 24'h0,      16'd5,    1'b0, 8'd4},  // R4 saturate
    '{1'b0, 6'h3F, 1'b0, 3'd2, 24'h800000, 16'd1,    1'b1, 8'd1},  // R1 sign bit
    '{1'b0, 6'h3B, 1'b0, 3'd2, 24'h000001, 16'd9600, 1'b0, 8'd6},  // R6 masked
    '{1'b1, 6'h3B, 1'b0, 3'd2, 24'h000001, 16'd1,    1'b1, 8'd7},  // R7 static
    '{1'b1, 6'h00, 1'b1, 3'd0, 24'h7FFFFF, 16'd1,    1'b0, 8'd8},  // R8 mute
    '{1'b0, 6'h00, 1'b0, 3'd5, 24'h123456, 16'd9600, 1'b0, 8'd9},  // R9 empty
    '{1'b0, 6'h3F, 1'b0, 3'd5, 24'h123456, 16'd1,    1'b1, 8'd5}   // R5 clear
  };

  task automatic check(input string req, input logic exp);
    checks++;
    if (silenceN !== exp) begin
      errors++;
      $display("FAIL %s: silenceN=%b expected %b", req, silenceN, exp);
    end
  endtask

  task automatic run(input logic [2:0] ch, input logic [23:0] val, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      sampleBus = '0;
      if (ch < 3'd6) sampleBus[ch*SW +: SW] = val;
    end
    @(negedge clk);
    sampleValid = 1'b0;
    sampleBus = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 reset state", 1'b1);
    check("R2 idle high", 1'b1);

    for (int s = 0; s < 9; s++) begin
      staticMode = STEPS[s].stat;
      chanEnable = STEPS[s].mask;
      muteReq    = STEPS[s].mute;
      run(STEPS[s].loudCh, STEPS[s].loudVal, int'(STEPS[s].nStrobe));
      check($sformatf("R%0d table step %0d", STEPS[s].req, s), STEPS[s].expN);
      muteReq = 1'b0;
      if (s == 7) begin
        // R3: loud samples without a strobe do nothing
        chanEnable = 6'h3F;
        sampleBus[5*SW +: SW] = 24'h000100;
        repeat (3) @(negedge clk);
        check("R3 no strobe, flag held", 1'b0);
        sampleBus = '0;
      end
    end

    // R8: mute without a strobe, then release
    muteReq = 1'b1;
    @(negedge clk);
    check("R8 mute idle", 1'b0);
    muteReq = 1'b0;
    @(negedge clk);
    check("R8 release", 1'b1);

    // R10: reset in the middle of a silence
    run(3'd7, 24'h0, QR);
    check("R4 silent again", 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset clears flag", 1'b1);
    run(3'd7, 24'h0, 1);
    check("R10 run restarted", 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule